// File: doc/BRIEF.md
# External Bus Cycle Stretch Controller

This block runs one external bus cycle at a time on a multiplexed memory interface. A CPU-side sequencer hands it a request carrying an address, a read/write flag, write data and a chip-select hit. The block then drives the external address, the strobes and the E phase. Every cycle opens with a single address period in which E is low. A data period follows in which E is high. That E-high period can be lengthened by 0 to 3 extra bus-clock periods, so that slow external devices get more time.

The stretch amount comes from a small configuration register. The value is sampled when a cycle is accepted, so a write to the register during a cycle only affects the next cycle. During the extra periods the block raises a stall output, which freezes the CPU sequencer. Read data is captured on the edge where E falls, and a one-cycle done pulse marks that edge. A separate reference tick for timers and baud generators keeps running at the plain bus rate and is never stretched.

Top module: `xbus_stretch_ctrl`

## Requirements
- R1: After reset, ext_e, ext_cs, ext_data_oe, cpu_stall and rd_done are 0, ext_rnw is 1, rd_data is 0, and the stretch setting is 0.
- R2: A request seen while idle starts a cycle. E is low for exactly one period, then high for 1+S periods, where S is the stretch value. rd_done fires on the edge where E falls, which is 2+S clocks after the accepting edge.
- R3: cpu_stall is high during exactly the S extra E-high periods. It is low during the first E-high period, during the address period and when idle.
- R4: On a write (req_rnw=0), ext_data_oe is high for every E-high period and ext_wdata holds the request's data. ext_data_oe is low at all other times, including every period of a read.
- R5: On a read (req_rnw=1), rd_data takes the value ext_din has in the final E-high period, which is captured on the E falling edge. A write leaves rd_data unchanged.
- R6: ext_addr, ext_rnw and ext_cs take the request's values in the address period and hold them through the whole E-high time. ext_cs drops to 0 and ext_rnw returns to 1 when the cycle ends.
- R7: A stretch value written with cfg_we during a cycle does not change the length of that cycle. The next cycle uses the new value.
- R8: ref_tick pulses once every TICK_DIV clocks, whatever bus cycles and stretching are in progress.
- R9: A request asserted while a cycle is in progress is ignored. It changes neither the running cycle nor ext_addr, and it starts no cycle afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the stretch setting |
| cfg_stretch | input | 2 | New stretch value (0..3 extra periods) |
| req_valid | input | 1 | Cycle request, taken only when idle |
| req_addr | input | ADDR_W | Request address |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_wdata | input | DATA_W | Write data |
| req_cs_hit | input | 1 | Chip-select hit for this access |
| ext_din | input | DATA_W | Data from the external bus |
| ext_addr | output | ADDR_W | External address |
| ext_wdata | output | DATA_W | External write data |
| ext_data_oe | output | 1 | Drive enable for ext_wdata |
| ext_rnw | output | 1 | External read/write strobe |
| ext_cs | output | 1 | External chip select |
| ext_e | output | 1 | E phase: low in the address period, high in the data period |
| rd_data | output | DATA_W | Captured read data |
| rd_done | output | 1 | One-cycle pulse on the E falling edge |
| cpu_stall | output | 1 | Freeze for the CPU sequencer during stretch |
| ref_tick | output | 1 | Unstretched timing reference tick |

## Verification
The assertions assume that req_valid is only acted on while the block is idle. They also assume that the CPU side drops or changes its request only as a well-behaved sequencer would. The checks do not depend on ext_din being stable, because the data is sampled only at the falling edge. The stimulus issues each request as a single-cycle pulse while idle. It raises stray requests and configuration writes only inside a running cycle, to exercise R7 and R9. It changes ext_din in the final E-high period so that an early or late capture shows up as a wrong value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;
endpackage

// File: rtl/xbus_stretch_reg.sv
module xbus_stretch_reg #(
  parameter int STRETCH_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [STRETCH_W-1:0] wval,
  output logic [STRETCH_W-1:0] stretch
);
  always_ff @(posedge clk) begin
    if (rst) stretch <= '0;
    else if (we) stretch <= wval;
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int STRETCH_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [STRETCH_W-1:0] stretch_cfg,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_rnw,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 req_cs_hit,
  output logic [ADDR_W-1:0]    addr_q,
  output logic [DATA_W-1:0]    wdata_q,
  output logic                 oe_q,
  output logic                 rnw_q,
  output logic                 cs_q,
  output logic                 e_q,
  output logic                 stall_q,
  output logic                 busy,
  output logic                 last_edge
);
  phase_t               phase;
  logic [STRETCH_W-1:0] remain;

  assign busy      = (phase != PH_IDLE);
  assign last_edge = (phase == PH_DATA) && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      remain  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      oe_q    <= 1'b0;
      rnw_q   <= 1'b1;
      cs_q    <= 1'b0;
      e_q     <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            phase   <= PH_ADDR;
            remain  <= stretch_cfg;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            rnw_q   <= req_rnw;
            cs_q    <= req_cs_hit;
          end
        end
        PH_ADDR: begin
          phase <= PH_DATA;
          e_q   <= 1'b1;
          oe_q  <= ~rnw_q;
        end
        PH_DATA: begin
          if (remain == '0) begin
            phase   <= PH_IDLE;
            e_q     <= 1'b0;
            oe_q    <= 1'b0;
            cs_q    <= 1'b0;
            rnw_q   <= 1'b1;
            stall_q <= 1'b0;
          end else begin
            remain  <= remain - 1'b1;
            stall_q <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xbus_rd_capture.sv
module xbus_rd_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_now,
  input  logic              is_read,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      done <= fall_now;
      if (fall_now && is_read) rdata <= din;
    end
  end
endmodule

// File: rtl/xbus_timebase.sv
module xbus_timebase #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  generate
    if (TICK_DIV <= 1) begin : g_every
      always_ff @(posedge clk) begin
        if (rst) tick <= 1'b0;
        else tick <= 1'b1;
      end
    end else begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          tick <= 1'b0;
        end else begin
          tick <= (cnt == CW'(TICK_DIV - 1));
          cnt  <= (cnt == CW'(TICK_DIV - 1)) ? '0 : cnt + 1'b1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/xbus_stretch_ctrl.sv
module xbus_stretch_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int STRETCH_W = 2,
  parameter int TICK_DIV  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [STRETCH_W-1:0] cfg_stretch,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_rnw,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic                 req_cs_hit,
  input  logic [DATA_W-1:0]    ext_din,
  output logic [ADDR_W-1:0]    ext_addr,
  output logic [DATA_W-1:0]    ext_wdata,
  output logic                 ext_data_oe,
  output logic                 ext_rnw,
  output logic                 ext_cs,
  output logic                 ext_e,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_done,
  output logic                 cpu_stall,
  output logic                 ref_tick
);
  logic [STRETCH_W-1:0] stretch_now;
  logic                 busy;
  logic                 last_edge;

  xbus_stretch_reg #(.STRETCH_W(STRETCH_W)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wval(cfg_stretch), .stretch(stretch_now)
  );

  xbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRETCH_W(STRETCH_W)) u_seq (
    .clk(clk), .rst(rst), .stretch_cfg(stretch_now),
    .req_valid(req_valid), .req_addr(req_addr), .req_rnw(req_rnw),
    .req_wdata(req_wdata), .req_cs_hit(req_cs_hit),
    .addr_q(ext_addr), .wdata_q(ext_wdata), .oe_q(ext_data_oe),
    .rnw_q(ext_rnw), .cs_q(ext_cs), .e_q(ext_e), .stall_q(cpu_stall),
    .busy(busy), .last_edge(last_edge)
  );

  xbus_rd_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .fall_now(last_edge), .is_read(ext_rnw),
    .din(ext_din), .rdata(rd_data), .done(rd_done)
  );

  xbus_timebase #(.TICK_DIV(TICK_DIV)) u_tb (
    .clk(clk), .rst(rst), .tick(ref_tick)
  );
endmodule

// File: rtl/xbus_stretch_chk.sv
module xbus_stretch_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int TICK_DIV = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_cs_hit,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [DATA_W-1:0] ext_wdata,
  input logic              ext_data_oe,
  input logic              ext_rnw,
  input logic              ext_cs,
  input logic              ext_e,
  input logic              rd_done,
  input logic              cpu_stall,
  input logic              ref_tick
);
  localparam int GW = $clog2(TICK_DIV + 2) + 1;
  logic [GW-1:0] gap;

  always_ff @(posedge clk) begin
    if (rst) gap <= '0;
    else if (ref_tick) gap <= '0;
    else gap <= gap + 1'b1;
  end

  AST_ADDR_PHASE_E_LOW: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_valid) |=> (!ext_e && ext_cs == $past(req_cs_hit) && ext_addr == $past(req_addr))); // R2
  AST_STALL_ONLY_E_HIGH: assert property (@(posedge clk) disable iff (rst)
    cpu_stall |-> ext_e); // R3
  AST_OE_WRITE_E_HIGH: assert property (@(posedge clk) disable iff (rst)
    ext_data_oe |-> (ext_e && !ext_rnw)); // R4
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (ext_data_oe && $past(ext_data_oe)) |-> $stable(ext_wdata)); // R4
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    rd_done |-> (!ext_e && $past(ext_e))); // R5
  AST_STROBES_HELD: assert property (@(posedge clk) disable iff (rst)
    (ext_e && $past(ext_e)) |-> ($stable(ext_cs) && $stable(ext_rnw) && $stable(ext_addr))); // R6
  AST_IDLE_CS_LOW: assert property (@(posedge clk) disable iff (rst)
    (!busy) |-> (!ext_cs && ext_rnw && !ext_e)); // R6
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    gap <= GW'(TICK_DIV)); // R8
endmodule

bind xbus_stretch_ctrl xbus_stretch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_DIV(TICK_DIV)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .req_valid(req_valid), .req_addr(req_addr),
  .req_cs_hit(req_cs_hit), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
  .ext_data_oe(ext_data_oe), .ext_rnw(ext_rnw), .ext_cs(ext_cs), .ext_e(ext_e),
  .rd_done(rd_done), .cpu_stall(cpu_stall), .ref_tick(ref_tick)
);

// File: tb/tb_xbus_stretch_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_stretch_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_stretch = '0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic req_rnw = 1'b1;
  logic [DW-1:0] req_wdata = '0;
  logic req_cs_hit = 1'b0;
  logic [DW-1:0] ext_din = '0;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_wdata, rd_data;
  logic ext_data_oe, ext_rnw, ext_cs, ext_e, rd_done, cpu_stall, ref_tick;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int cur_s = 0;
  logic [DW-1:0] last_rd = '0;

  always #2.5 clk = ~clk;

  xbus_stretch_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STRETCH_W(2), .TICK_DIV(DIV)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_stretch(cfg_stretch),
    .req_valid(req_valid), .req_addr(req_addr), .req_rnw(req_rnw),
    .req_wdata(req_wdata), .req_cs_hit(req_cs_hit), .ext_din(ext_din),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_data_oe(ext_data_oe),
    .ext_rnw(ext_rnw), .ext_cs(ext_cs), .ext_e(ext_e), .rd_data(rd_data),
    .rd_done(rd_done), .cpu_stall(cpu_stall), .ref_tick(ref_tick)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int s);
    return s + 2;
  endfunction

  task automatic set_stretch(input int v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_stretch = 2'(v);
    @(negedge clk);
    cfg_we = 1'b0;
    cur_s = v;
  endtask

  // One bus cycle; optional mid-cycle stretch write (R7) and stray request (R9)
  task automatic bus_cycle(input logic [AW-1:0] a, input bit rnw, input logic [DW-1:0] wd,
                           input bit cs, input logic [DW-1:0] din_final,
                           input bit mid_cfg, input int new_s, input bit stray);
    int s;
    int len;
    s = cur_s;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_rnw = rnw; req_wdata = wd; req_cs_hit = cs;
    ext_din = ~din_final;
    len = 0;
    @(negedge clk); len++;
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~wd; req_rnw = ~rnw; req_cs_hit = ~cs;
    chk(ext_e == 1'b0, "R2 address period E low", ext_e, 0);
    chk(ext_addr == a && ext_rnw == rnw && ext_cs == cs, "R6 address phase strobes", ext_addr, a);
    chk(cpu_stall == 1'b0 && ext_data_oe == 1'b0, "R3/R4 address period quiet", {cpu_stall, ext_data_oe}, 0);
    for (int i = 0; i <= s; i++) begin
      @(negedge clk); len++;
      cfg_we = 1'b0;
      req_valid = 1'b0;
      chk(ext_e == 1'b1, "R2 E high in data period", ext_e, 1);
      chk(cpu_stall == (i > 0), "R3 stall only in extra periods", cpu_stall, (i > 0));
      chk(ext_data_oe == !rnw, "R4 output enable on write", ext_data_oe, !rnw);
      if (!rnw) chk(ext_wdata == wd, "R4 write data held", ext_wdata, wd);
      chk(ext_addr == a && ext_rnw == rnw && ext_cs == cs, "R6 strobes held", ext_addr, a);
      chk(rd_done == 1'b0, "R2 no early done", rd_done, 0);
      if (i == 0 && mid_cfg) begin cfg_we = 1'b1; cfg_stretch = 2'(new_s); end
      if (i == 0 && stray) begin req_valid = 1'b1; req_addr = a ^ 16'h5A5A; req_cs_hit = 1'b1; end
      if (i == s) ext_din = din_final;
    end
    @(negedge clk); len++;
    cfg_we = 1'b0;
    req_valid = 1'b0;
    chk(rd_done == 1'b1, "R2 done at E fall", rd_done, 1);
    chk(len == exp_len(s) + 1, "R2 cycle length", len - 1, exp_len(s));
    chk(ext_e == 1'b0 && ext_cs == 1'b0 && ext_rnw == 1'b1 && ext_data_oe == 1'b0,
        "R6 strobes released", {ext_e, ext_cs, ext_rnw, ext_data_oe}, 4'b0010);
    if (rnw) last_rd = din_final;
    chk(rd_data == last_rd, "R5 read capture at fall", rd_data, last_rd);
    if (mid_cfg) cur_s = new_s;
    @(negedge clk);
    chk(rd_done == 1'b0, "R5 done is one cycle", rd_done, 0);
    if (stray) begin
      chk(ext_addr == a && ext_cs == 1'b0, "R9 stray request ignored", ext_addr, a);
    end
  endtask

  // R8: tick spacing observed independently
  int tick_gap = -1;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (ref_tick) begin
        if (tick_gap >= 0) chk(tick_gap == DIV - 1, "R8 tick spacing", tick_gap, DIV - 1);
        tick_gap = 0;
      end else if (tick_gap >= 0) tick_gap++;
      else if (tick_gap < 0) tick_gap = -1;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h1234);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ext_e == 0 && ext_cs == 0 && ext_data_oe == 0 && cpu_stall == 0 && rd_done == 0
        && ext_rnw == 1 && rd_data == 0, "R1 reset state",
        {ext_e, ext_cs, ext_data_oe, cpu_stall, rd_done, ext_rnw}, 6'b000001);
    // R1: stretch resets to 0 -> two-period cycle
    bus_cycle(16'h1000, 1'b1, 16'h0, 1'b1, 16'hBEEF, 0, 0, 0);
    // directed: each stretch value, read and write
    for (int v = 0; v < 4; v++) begin
      set_stretch(v);
      bus_cycle(16'h2000 + 16'(v), 1'b1, 16'h0, 1'b1, 16'hA500 + 16'(v), 0, 0, 0);
      bus_cycle(16'h3000 + 16'(v), 1'b0, 16'hC300 + 16'(v), 1'b0, 16'h1111, 0, 0, 0);
    end
    // R7: mid-cycle stretch change
    set_stretch(1);
    bus_cycle(16'h4000, 1'b1, 16'h0, 1'b1, 16'h4242, 1, 3, 0);
    bus_cycle(16'h4001, 1'b1, 16'h0, 1'b1, 16'h4343, 0, 0, 0);
    set_stretch(0);
    bus_cycle(16'h4002, 1'b0, 16'h7777, 1'b1, 16'h0, 1, 2, 0);
    bus_cycle(16'h4003, 1'b0, 16'h8888, 1'b1, 16'h0, 0, 0, 0);
    // R9: stray request during a cycle
    bus_cycle(16'h5000, 1'b1, 16'h0, 1'b1, 16'h5151, 0, 0, 1);
    set_stretch(0);
    bus_cycle(16'h5001, 1'b0, 16'h9999, 1'b0, 16'h0, 0, 0, 1);
    // random mix
    for (int k = 0; k < 40; k++) begin
      bit r;
      if ($urandom_range(0, 2) == 0) set_stretch($urandom_range(0, 3));
      r = 1'($urandom_range(0, 1));
      bus_cycle(16'($urandom), r, 16'($urandom), 1'($urandom_range(0, 1)), 16'($urandom),
                1'($urandom_range(0, 3) == 0), $urandom_range(0, 3),
                1'($urandom_range(0, 3) == 0));
    end
    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule